// File: doc/BRIEF.md
# Indexed Multiprocessor Interrupt Distributor

This block collects level-sensitive interrupt sources and hands each one to a small set of CPUs. Software never edits enable or mask bitmaps directly. It writes a source number to a set register or a clear register. A global enable is kept for each source, and each CPU has its own mask for each source. A routing word per source selects which physical CPUs may see it.

The register port has two views. With `percpu_i` low, accesses reach the shared registers. With `percpu_i` high, they reach the per-CPU registers of the CPU named on `cpu_id_i`. Each CPU has one interrupt line. It learns which source to service by reading its acknowledge register, which returns the lowest-numbered source delivered to it. If nothing is delivered, it returns a spurious code. Reading the acknowledge register has no side effect. A source stays pending for as long as its input is high, and nothing stops two CPUs from both being told about the same source.

Top module: `irq_dist`

## Requirements
- R1: A read of shared offset 0x00 returns the implemented source count in bits [11:2], with all other bits zero.
- R2: A write of source number n to shared offset 0x30 sets the global enable of n. A write of n to shared offset 0x34 clears it.
- R3: A per-CPU write of n to offset 0x48 masks source n for the CPU on `cpu_id_i`, and a per-CPU write of n to offset 0x4C unmasks it. The masks of other CPUs do not change.
- R4: The routing word of source n is at shared offset 0x100 + 4n. Bit c allows delivery to CPU c. It reads back with all bits at and above the CPU count as zero.
- R5: Source n is delivered to CPU c only while its input is high, it is globally enabled, routing bit c is set, and it is unmasked for c. `irq_o[c]` is high in the same cycle exactly when at least one source is delivered to c.
- R6: A per-CPU read of offset 0x44 returns, one cycle later, the lowest-numbered source delivered to that CPU in bits [9:0], with the upper bits zero.
- R7: When no source is delivered to the reading CPU, the acknowledge read returns 0x3FF.
- R8: Acknowledge reads do not clear anything. A source that stays high is reported again on every read, and it is reported to every CPU it reaches.
- R9: After reset all global enables are clear, all masks are set, and all routing words are zero. So every `irq_o` is low, every acknowledge read is 0x3FF, and every routing word reads zero.
- R10: A source number at or above the implemented count, written to any set or clear register, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive source inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| percpu_i | input | 1 | Selects the per-CPU view when high |
| cpu_id_i | input | CPU_W | Accessing CPU for the per-CPU view |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after rd_en_i |
| irq_o | output | NUM_CPU | Interrupt line per CPU |

## Verification
A fixed routing setup is used: one source goes to two CPUs, one to a single CPU, and one to all four. A table of source patterns is then applied to it. The patterns separate the lowest-index choice from plain presence, per-CPU routing from shared enables, and the spurious code from a real index. Directed tests flip one mask or one enable at a time, and each such test shows that only the intended CPU or source changes. Out-of-range indices are chosen so that their low bits alias to a live source, which exposes any truncation of the index before the range check.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int IDX_W = 10;
  localparam logic [IDX_W-1:0] SPURIOUS = '1;

  // shared view
  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_EN_SET  = 'h030;
  localparam int OFS_EN_CLR  = 'h034;
  localparam int OFS_ROUTE   = 'h100;
  // per-cpu view
  localparam int OFS_ACK     = 'h044;
  localparam int OFS_MSK_SET = 'h048;
  localparam int OFS_MSK_CLR = 'h04C;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic msk_set;
    logic msk_clr;
    logic route_wr;
  } wr_dec_t;
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  wr_dec_t                           dec_i,
  input  logic [SRC_W-1:0]                  idx_i,
  input  logic [CPU_W-1:0]                  cpu_i,
  input  logic [SRC_W-1:0]                  route_idx_i,
  input  logic [NUM_CPU-1:0]                route_data_i,
  output logic [NUM_SRC-1:0]                en_o,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_o,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o
);
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else begin
      if (dec_i.en_set)   en_q[idx_i]         <= 1'b1;
      if (dec_i.en_clr)   en_q[idx_i]         <= 1'b0;
      if (dec_i.msk_set)  mask_q[cpu_i][idx_i] <= 1'b1;
      if (dec_i.msk_clr)  mask_q[cpu_i][idx_i] <= 1'b0;
      if (dec_i.route_wr) route_q[route_idx_i] <= route_data_i;
    end
  end

  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_dist_find.sv
module irq_dist_find
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    idx_o = SPURIOUS;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic               percpu_i,
  input  logic [CPU_W-1:0]   cpu_id_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [IDX_W-1:0]  SRC_LIM    = IDX_W'(NUM_SRC);
  localparam logic [CPU_W:0]    CPU_LIM    = (CPU_W+1)'(NUM_CPU);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_EN_SET   = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR   = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_ROUTE    = ADDR_W'(OFS_ROUTE);
  localparam logic [ADDR_W-1:0] A_ACK      = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MSK_SET  = ADDR_W'(OFS_MSK_SET);
  localparam logic [ADDR_W-1:0] A_MSK_CLR  = ADDR_W'(OFS_MSK_CLR);
  localparam logic [ADDR_W-3:0] ROUTE_LIM  = (ADDR_W-2)'(NUM_SRC);

  // ---------------- decode ----------------
  logic              idx_ok, cpu_ok, route_hit;
  logic [SRC_W-1:0]  idx, route_idx;
  logic [ADDR_W-1:0] route_ofs;
  wr_dec_t           dec;

  assign idx_ok    = wdata_i[IDX_W-1:0] < SRC_LIM;
  assign idx       = wdata_i[SRC_W-1:0];
  assign cpu_ok    = {1'b0, cpu_id_i} < CPU_LIM;
  assign route_ofs = addr_i - A_ROUTE;
  assign route_hit = (addr_i >= A_ROUTE) && (route_ofs[1:0] == 2'b00)
                     && (route_ofs[ADDR_W-1:2] < ROUTE_LIM);
  assign route_idx = route_ofs[SRC_W+1:2];

  always_comb begin
    dec          = '0;
    dec.en_set   = wr_en_i && !percpu_i && addr_i == A_EN_SET && idx_ok;
    dec.en_clr   = wr_en_i && !percpu_i && addr_i == A_EN_CLR && idx_ok;
    dec.msk_set  = wr_en_i &&  percpu_i && addr_i == A_MSK_SET && idx_ok && cpu_ok;
    dec.msk_clr  = wr_en_i &&  percpu_i && addr_i == A_MSK_CLR && idx_ok && cpu_ok;
    dec.route_wr = wr_en_i && !percpu_i && route_hit;
  end

  // ---------------- state ----------------
  logic [NUM_SRC-1:0]              en;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route;

  irq_dist_regs #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dec_i        (dec),
    .idx_i        (idx),
    .cpu_i        (cpu_id_i),
    .route_idx_i  (route_idx),
    .route_data_i (wdata_i[NUM_CPU-1:0]),
    .en_o         (en),
    .mask_o       (mask),
    .route_o      (route)
  );

  // ---------------- delivery per cpu ----------------
  logic [NUM_CPU-1:0][NUM_SRC-1:0] route_col;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;
  logic [NUM_CPU-1:0][IDX_W-1:0]   ack_idx;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign route_col[c][s] = route[s][c];
    end
    assign pend[c] = src_i & en & ~mask[c] & route_col[c];

    irq_dist_find #(.NUM_SRC(NUM_SRC)) i_find (
      .vec_i (pend[c]),
      .any_o (irq_o[c]),
      .idx_o (ack_idx[c])
    );
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_next, rdata_q;

  always_comb begin
    rd_next = '0;
    if (percpu_i) begin
      if (addr_i == A_ACK)
        rd_next = cpu_ok ? DATA_W'(ack_idx[cpu_id_i]) : DATA_W'(SPURIOUS);
    end else if (addr_i == A_CTRL) begin
      rd_next = DATA_W'({SRC_LIM, 2'b00});
    end else if (route_hit) begin
      rd_next = DATA_W'(route[route_idx]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:IDX_W], wdata_i[IDX_W-1:SRC_W]};
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               rd_en_i,
  input logic               percpu_i,
  input logic [CPU_W-1:0]   cpu_id_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_CPU-1:0] irq_o
);
  logic ack_rd, ctrl_rd, irq_sel, started_q;

  assign ack_rd  = rd_en_i && percpu_i && addr_i == ADDR_W'(OFS_ACK);
  assign ctrl_rd = rd_en_i && !percpu_i && addr_i == ADDR_W'(OFS_CTRL);
  assign irq_sel = ({1'b0, cpu_id_i} < (CPU_W+1)'(NUM_CPU)) ? irq_o[cpu_id_i] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assert_ctrl_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |=> rdata_o == DATA_W'(NUM_SRC * 4));

  assert_irq_needs_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|src_i));

  assert_ack_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && irq_sel) |=> rdata_o < DATA_W'(NUM_SRC));

  assert_ack_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !irq_sel) |=> rdata_o == DATA_W'(SPURIOUS));

  assert_reset_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> irq_o == '0);
endmodule

bind irq_dist irq_dist_chk #(
  .NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_irq_dist_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .rd_en_i  (rd_en_i),
  .percpu_i (percpu_i),
  .cpu_id_i (cpu_id_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o)
);

// File: tb/test_irq_dist.sv
module test_irq_dist;
  localparam int NUM_CPU = 4;
  localparam int NUM_SRC = 64;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_SRC-1:0] src_i = '0;
  logic               wr_en_i = 1'b0, rd_en_i = 1'b0, percpu_i = 1'b0;
  logic [1:0]         cpu_id_i = '0;
  logic [11:0]        addr_i = '0;
  logic [31:0]        wdata_i = '0;
  logic [31:0]        rdata_o;
  logic [NUM_CPU-1:0] irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_dist i_irq_dist (.*);

  typedef struct packed {
    logic [63:0]      src;
    logic [3:0]       irq;
    logic [3:0][9:0]  ack;  // [3]=cpu3 ... [0]=cpu0
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0,                   4'b0000, {10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF}},
    '{64'h8,                   4'b0011, {10'h3FF, 10'h3FF, 10'd3,   10'd3  }},
    '{64'h28,                  4'b0011, {10'h3FF, 10'h3FF, 10'd3,   10'd3  }},
    '{64'h0000_0100_0000_0420, 4'b1111, {10'd40,  10'd10,  10'd5,   10'd40 }},
    '{64'h8000_0000_0000_0000, 4'b1111, {10'd63,  10'd63,  10'd63,  10'd63 }},
    '{64'h8000_0100_0000_0008, 4'b1111, {10'd40,  10'd63,  10'd3,   10'd3  }},
    '{64'h80,                  4'b0000, {10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF}},
    '{64'h406,                 4'b0100, {10'h3FF, 10'd10,  10'h3FF, 10'h3FF}}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit pc, input int cpu, input int addr, input int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; percpu_i = pc; cpu_id_i = 2'(cpu); addr_i = 12'(addr); wdata_i = 32'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input bit pc, input int cpu, input int addr, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; percpu_i = pc; cpu_id_i = 2'(cpu); addr_i = 12'(addr);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic chk_ack(input int cpu, input int exp, input string req);
    logic [31:0] d;
    rd(1'b1, cpu, 'h44, d);
    check(d == 32'(exp), req, d, exp);
  endtask

  task automatic set_src(input logic [63:0] s);
    @(negedge clk_i);
    src_i = s;
  endtask

  initial begin
    logic [31:0] d;
    int srcs [5] = '{3, 5, 10, 40, 63};
    int routes [5] = '{'b0011, 'b0010, 'b0100, 'b1001, 'b1111};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state, with every source driven high
    set_src('1);
    @(negedge clk_i);
    check(irq_o == 4'b0, "R9 irq after reset", irq_o, 0);
    for (int c = 0; c < NUM_CPU; c++) chk_ack(c, 'h3FF, "R9 ack after reset");
    rd(1'b0, 0, 'h100 + 4 * 40, d);
    check(d == 0, "R9 route after reset", d, 0);
    // enable and route without unmasking: masks still set from reset
    wr(1'b0, 0, 'h30, 3);
    wr(1'b0, 0, 'h100 + 4 * 3, 'hF);
    @(negedge clk_i);
    check(irq_o == 4'b0, "R9 masks set after reset", irq_o, 0);

    // R1 control register
    rd(1'b0, 0, 'h00, d);
    check(d == 32'(NUM_SRC * 4), "R1 control count", d, NUM_SRC * 4);

    // R4 routing readback, upper bits dropped
    rd(1'b0, 0, 'h100 + 4 * 3, d);
    check(d == 32'hF, "R4 route readback", d, 'hF);

    // setup
    for (int i = 0; i < 5; i++) begin
      wr(1'b0, 0, 'h30, srcs[i]);
      wr(1'b0, 0, 'h100 + 4 * srcs[i], routes[i] | 'hFFF0);
      for (int c = 0; c < NUM_CPU; c++) wr(1'b1, c, 'h4C, srcs[i]);
    end
    rd(1'b0, 0, 'h100 + 4 * 40, d);
    check(d == 32'h9, "R4 route masked to cpu bits", d, 'h9);

    // table walk: R5 irq lines, R6 lowest index, R7 spurious
    for (int v = 0; v < 8; v++) begin
      set_src(VECS[v].src);
      @(negedge clk_i);
      check(irq_o == VECS[v].irq, "R5 irq pattern", irq_o, VECS[v].irq);
      for (int c = 0; c < NUM_CPU; c++)
        chk_ack(c, int'(VECS[v].ack[c]), VECS[v].ack[c] == 10'h3FF ? "R7 spurious" : "R6 lowest index");
    end

    // R8 repeated ack with held level, reported to two cpus
    set_src(64'h8);
    chk_ack(0, 3, "R8 first read cpu0");
    chk_ack(0, 3, "R8 second read cpu0");
    chk_ack(1, 3, "R8 shared source cpu1");

    // R3 mask only affects the accessing cpu
    wr(1'b1, 0, 'h48, 3);
    @(negedge clk_i);
    check(irq_o == 4'b0010, "R3 mask cpu0 irq", irq_o, 'b0010);
    chk_ack(0, 'h3FF, "R3 masked cpu0");
    chk_ack(1, 3, "R3 cpu1 unaffected");
    wr(1'b1, 0, 'h4C, 3);
    chk_ack(0, 3, "R3 unmask cpu0");

    // R2 global enable clear/set
    set_src(64'h8000_0000_0000_0000);
    wr(1'b0, 0, 'h34, 63);
    @(negedge clk_i);
    check(irq_o == 4'b0, "R2 enable cleared", irq_o, 0);
    wr(1'b0, 0, 'h30, 63);
    @(negedge clk_i);
    check(irq_o == 4'b1111, "R2 enable set", irq_o, 'b1111);

    // R10 out of range index aliasing source 3 (67 = 64 + 3)
    set_src(64'h8);
    wr(1'b0, 0, 'h34, 67);
    wr(1'b1, 0, 'h48, 67);
    wr(1'b1, 1, 'h48, 1023);
    @(negedge clk_i);
    check(irq_o == 4'b0011, "R10 out of range ignored irq", irq_o, 'b0011);
    chk_ack(0, 3, "R10 out of range ignored cpu0");
    set_src(64'h80);
    wr(1'b0, 0, 'h30, 64 + 7);
    wr(1'b0, 0, 'h100 + 4 * 7, 'hF);
    wr(1'b1, 2, 'h4C, 64 + 7);
    check(irq_o == 4'b0, "R10 out of range set ignored", irq_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule